// File: doc/BRIEF.md
# Run-Time Configuration Register Port

This block is the slave side of a small synchronous parallel port. A functional block uses it so that neighbouring user logic can change the block's settings while it runs. The port has a request enable, a write/read select, an address, a write-data bus, a separate read-data bus and a one-cycle acknowledge. Behind the port sit three kinds of word.

The first kind is the read/write configuration word. It is stored, it starts from a value given by a parameter, and its register output drives the controlled logic at all times. The second kind is the read-only status word, which is sampled from the controlled block when a read is accepted. The third kind is the write-only function-enable word. It is not stored: a write to it goes out to the controlled block as a one-cycle pulse.

A status word and an enable word may sit at the same address. The direction of the access then selects which one is used. Every accepted access is answered with exactly one acknowledge, including accesses to addresses that are unmapped or that do not support the direction.

Top module: `cfg_reg_port`

## Requirements
- R1: While `rst_n` is low at a rising edge, every configuration word is loaded with its slice of `RW_INIT`, and `ack`, `rdata` and `enable_pulse` are cleared. With the defaults, word 0 is 16'h1111, word 1 is 16'h2222, word 2 is 16'h3333 and word 3 is 16'h4444.
- R2: A request is accepted at a rising edge where `req_en` is 1 and `ack` is 0. `ack` is then high for exactly the one following cycle.
- R3: An accepted write (`req_wr`=1) to a configuration address (defaults: 0 to 3) stores `wdata`. Word i is `cfg_bits[i*DW +: DW]`, bit 0 is the least significant bit, and the new value appears in the `ack` cycle.
- R4: An accepted read (`req_wr`=0) of a configuration address returns the stored word on `rdata` in the `ack` cycle. `rdata` is zero in every cycle that is not the acknowledge of a read.
- R5: An accepted read of a status address (defaults: 4 and 5, status word j at `status_in[j*DW +: DW]`) returns the status value present at the accepting edge.
- R6: An accepted write to an enable address (defaults: 5 and 6, enable word k at `enable_pulse[k*DW +: DW]`) drives `wdata` on that enable word for only the `ack` cycle and stores nothing. A read of enable-only address 6 returns zero.
- R7: On shared address 5, a read returns status word 1, and a write pulses enable word 0 without changing any configuration word.
- R8: A write to status-only address 4 is discarded: there is no change to `cfg_bits` and no pulse, and `ack` is still produced.
- R9: A read of an unmapped address (defaults: 7 to 15) returns zero, and a write to one changes nothing. Both still produce `ack`.
- R10: While `req_en` is 0, `req_wr`, `req_addr` and `wdata` have no effect: there is no `ack`, no pulse and no change to any configuration word.
- R11: A request presented in a cycle where `ack` is high is ignored. It causes no second `ack`, no write and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_en | input | 1 | Access request enable |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid in the acknowledge cycle of a read, zero otherwise |
| ack | output | 1 | One-cycle acknowledge, one cycle after acceptance |
| cfg_bits | output | NUM_RW*DW | Configuration words driving the controlled logic |
| status_in | input | NUM_RO*DW | Status words from the controlled logic |
| enable_pulse | output | NUM_WO*DW | One-cycle function-enable words toward the controlled logic |

## Verification
The assertions assume that `req_wr` is driven to a known level whenever `req_en` is high. They also assume that the address ranges set by the parameters for configuration words and status words do not overlap. The bench uses only the default map, where the ranges are disjoint. It drives every request on the falling edge with all fields set, and it raises `req_en` while `ack` is high only in the scenario that tests that a request arriving during the acknowledge is ignored.

// File: rtl/cfg_port_pkg.sv
// Package: shared types for the configuration register port.
// Assumes: nothing beyond being compiled before the modules that import it.
package cfg_port_pkg;
    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;
endpackage

// File: rtl/cfg_addr_decode.sv
// Module: compares one address against a contiguous range of COUNT words
// that starts at BASE, and gives a one-hot-or-zero hit vector.
// Assumes: BASE + COUNT - 1 fits in AW bits.
module cfg_addr_decode #(
    parameter int AW    = 4,
    parameter int COUNT = 1,
    parameter int BASE  = 0
) (
    input  logic [AW-1:0]    addr,
    output logic [COUNT-1:0] hit
);
    // One comparator for each word in the range.
    for (genvar i = 0; i < COUNT; i++) begin : g_cmp
        assign hit[i] = (addr == AW'(BASE + i));
    end
endmodule

// File: rtl/cfg_port_ctrl.sv
// Module: decides which requests are accepted and produces the one-cycle
// acknowledge.
// Assumes: a request that arrives while the acknowledge is high is dropped.
module cfg_port_ctrl
    import cfg_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_en,
    input  logic req_wr,
    output logic wr_accept,
    output logic rd_accept,
    output logic ack
);
    logic accept;
    op_e  op;

    // Classify the request and gate it with the busy (ack) state.
    always_comb begin
        op        = op_e'(req_wr);
        accept    = req_en & ~ack;
        wr_accept = accept & (op == OP_WRITE);
        rd_accept = accept & (op == OP_READ);
    end

    // The acknowledge follows each accepted request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= accept;
    end
endmodule

// File: rtl/cfg_rw_bank.sv
// Module: stored configuration words with parameter preset values; their
// outputs drive the controlled logic continuously.
// Assumes: hit is one-hot or zero.
module cfg_rw_bank #(
    parameter int              DW   = 16,
    parameter int              NUM  = 4,
    parameter logic [NUM*DW-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_accept,
    input  logic [NUM-1:0]    hit,
    input  logic [DW-1:0]     wdata,
    output logic [NUM*DW-1:0] words
);
    for (genvar i = 0; i < NUM; i++) begin : g_word
        logic [DW-1:0] q;
        // Load the preset on reset, otherwise take an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n)                  q <= INIT[i*DW +: DW];
            else if (wr_accept && hit[i]) q <= wdata;
        end
        assign words[i*DW +: DW] = q;
    end
endmodule

// File: rtl/cfg_read_mux.sv
// Module: selects the word for a read and registers it, so that it is valid
// in the acknowledge cycle and zero at all other times.
// Assumes: configuration and status ranges do not overlap.
module cfg_read_mux #(
    parameter int DW     = 16,
    parameter int NUM_RW = 4,
    parameter int NUM_RO = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_accept,
    input  logic [NUM_RW-1:0]    rw_hit,
    input  logic [NUM_RW*DW-1:0] rw_words,
    input  logic [NUM_RO-1:0]    ro_hit,
    input  logic [NUM_RO*DW-1:0] ro_words,
    output logic [DW-1:0]        rdata
);
    logic [DW-1:0] sel;

    // OR together the hit words; unmapped and enable-only addresses give zero.
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_RW; i++)
            if (rw_hit[i]) sel = sel | rw_words[i*DW +: DW];
        for (int j = 0; j < NUM_RO; j++)
            if (ro_hit[j]) sel = sel | ro_words[j*DW +: DW];
    end

    // Capture on an accepted read, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdata <= '0;
        else if (rd_accept) rdata <= sel;
        else                rdata <= '0;
    end
endmodule

// File: rtl/cfg_reg_port.sv
// Module: top of the run-time configuration register port. It holds the
// configuration words, returns status words, and turns function-enable
// writes into one-cycle pulses.
// Assumes: clk is the only clock; rst_n is synchronous and active low.
module cfg_reg_port #(
    parameter int AW      = 4,
    parameter int DW      = 16,
    parameter int NUM_RW  = 4,
    parameter int RW_BASE = 0,
    parameter int NUM_RO  = 2,
    parameter int RO_BASE = 4,
    parameter int NUM_WO  = 2,
    parameter int WO_BASE = 5,
    parameter logic [NUM_RW*DW-1:0] RW_INIT = 64'h4444_3333_2222_1111
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_en,
    input  logic                 req_wr,
    input  logic [AW-1:0]        req_addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic                 ack,
    output logic [NUM_RW*DW-1:0] cfg_bits,
    input  logic [NUM_RO*DW-1:0] status_in,
    output logic [NUM_WO*DW-1:0] enable_pulse
);
    logic              wr_accept;
    logic              rd_accept;
    logic [NUM_RW-1:0] rw_hit;
    logic [NUM_RO-1:0] ro_hit;
    logic [NUM_WO-1:0] wo_hit;

    cfg_port_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_en    (req_en),
        .req_wr    (req_wr),
        .wr_accept (wr_accept),
        .rd_accept (rd_accept),
        .ack       (ack)
    );

    cfg_addr_decode #(.AW(AW), .COUNT(NUM_RW), .BASE(RW_BASE)) u_dec_rw (
        .addr (req_addr),
        .hit  (rw_hit)
    );

    cfg_addr_decode #(.AW(AW), .COUNT(NUM_RO), .BASE(RO_BASE)) u_dec_ro (
        .addr (req_addr),
        .hit  (ro_hit)
    );

    cfg_addr_decode #(.AW(AW), .COUNT(NUM_WO), .BASE(WO_BASE)) u_dec_wo (
        .addr (req_addr),
        .hit  (wo_hit)
    );

    cfg_rw_bank #(.DW(DW), .NUM(NUM_RW), .INIT(RW_INIT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_accept),
        .hit       (rw_hit),
        .wdata     (wdata),
        .words     (cfg_bits)
    );

    cfg_read_mux #(.DW(DW), .NUM_RW(NUM_RW), .NUM_RO(NUM_RO)) u_rmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_accept (rd_accept),
        .rw_hit    (rw_hit),
        .rw_words  (cfg_bits),
        .ro_hit    (ro_hit),
        .ro_words  (status_in),
        .rdata     (rdata)
    );

    for (genvar k = 0; k < NUM_WO; k++) begin : g_pulse
        logic [DW-1:0] p;
        // Drive the write data for one cycle on the hit enable word.
        always_ff @(posedge clk) begin
            if (!rst_n)                     p <= '0;
            else if (wr_accept && wo_hit[k]) p <= wdata;
            else                            p <= '0;
        end
        assign enable_pulse[k*DW +: DW] = p;
    end
endmodule

// File: rtl/cfg_reg_port_checker.sv
// Module: protocol and storage properties of cfg_reg_port, attached by bind.
// Assumes: req_wr is known whenever req_en is high.
module cfg_reg_port_checker #(
    parameter int DW     = 16,
    parameter int NUM_RW = 4,
    parameter int NUM_WO = 2,
    parameter logic [NUM_RW*DW-1:0] RW_INIT = '0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_en,
    input logic                 req_wr,
    input logic [DW-1:0]        rdata,
    input logic                 ack,
    input logic [NUM_RW*DW-1:0] cfg_bits,
    input logic [NUM_WO*DW-1:0] enable_pulse
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cfg_bits == RW_INIT && !ack && rdata == '0));

    assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && !ack) |=> ack);

    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_rdata_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> rdata == '0);

    assert_pulse_in_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|enable_pulse) |-> (ack && $past(req_wr)));

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_en && !ack && req_wr) |=> $stable(cfg_bits));

    assert_no_ack_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_en || ack) |=> !ack);
endmodule

bind cfg_reg_port cfg_reg_port_checker #(
    .DW(DW), .NUM_RW(NUM_RW), .NUM_WO(NUM_WO), .RW_INIT(RW_INIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_en       (req_en),
    .req_wr       (req_wr),
    .rdata        (rdata),
    .ack          (ack),
    .cfg_bits     (cfg_bits),
    .enable_pulse (enable_pulse)
);

// File: tb/cfg_reg_port_bench.sv
module cfg_reg_port_bench;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int NRW = 4;
    localparam int NRO = 2;
    localparam int NWO = 2;
    localparam logic [NRW*DW-1:0] INIT = 64'h4444_3333_2222_1111;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_en = 1'b0;
    logic                 req_wr = 1'b0;
    logic [AW-1:0]        req_addr = '0;
    logic [DW-1:0]        wdata = '0;
    logic [DW-1:0]        rdata;
    logic                 ack;
    logic [NRW*DW-1:0]    cfg_bits;
    logic [NRO*DW-1:0]    status_in = '0;
    logic [NWO*DW-1:0]    enable_pulse;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [NRW*DW-1:0] model;

    // Results of the last access.
    logic              a_ack1, a_ack2;
    logic [DW-1:0]     a_rd;
    logic [NWO*DW-1:0] a_p1, a_p2;

    always #2.5 clk = ~clk;

    cfg_reg_port u_cfg_reg_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_en       (req_en),
        .req_wr       (req_wr),
        .req_addr     (req_addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .ack          (ack),
        .cfg_bits     (cfg_bits),
        .status_in    (status_in),
        .enable_pulse (enable_pulse)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One access: drive on a falling edge, sample the ack cycle and the one after.
    task automatic access(input logic wr, input logic [AW-1:0] addr, input logic [DW-1:0] d);
        @(negedge clk);
        req_en = 1'b1; req_wr = wr; req_addr = addr; wdata = d;
        @(negedge clk);
        req_en = 1'b0; req_wr = 1'b0; req_addr = '0; wdata = '0;
        a_ack1 = ack; a_rd = rdata; a_p1 = enable_pulse;
        @(negedge clk);
        a_ack2 = ack; a_p2 = enable_pulse;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", "cfg after reset", 64'(cfg_bits), 64'(INIT));
        check("R1", "ack after reset", 64'(ack), 64'd0);
        check("R1", "rdata after reset", 64'(rdata), 64'd0);
        check("R1", "pulse after reset", 64'(enable_pulse), 64'd0);
    endtask

    task automatic t_rw;
        access(1'b0, 4'd3, '0);
        check("R4", "read init word3", 64'(a_rd), 64'h4444);
        check("R2", "ack in ack cycle", 64'(a_ack1), 64'd1);
        check("R2", "ack drops after one", 64'(a_ack2), 64'd0);
        access(1'b1, 4'd2, 16'hA5C3);
        model[2*DW +: DW] = 16'hA5C3;
        check("R3", "cfg after write w2", 64'(cfg_bits), 64'(model));
        check("R4", "rdata zero on write ack", 64'(a_rd), 64'd0);
        access(1'b0, 4'd2, '0);
        check("R4", "read back w2", 64'(a_rd), 64'hA5C3);
        access(1'b1, 4'd0, 16'h8001);
        model[0 +: DW] = 16'h8001;
        check("R3", "cfg after write w0", 64'(cfg_bits), 64'(model));
    endtask

    task automatic t_status;
        status_in = {16'hBEEF, 16'h1234};
        access(1'b0, 4'd4, '0);
        check("R5", "status word0 read", 64'(a_rd), 64'h1234);
        @(negedge clk);
        req_en = 1'b1; req_wr = 1'b0; req_addr = 4'd5;
        @(negedge clk);
        req_en = 1'b0;
        status_in = {16'h0F0F, 16'h1234};
        #1;
        check("R5", "status sampled at accept", 64'(rdata), 64'hBEEF);
        check("R7", "shared read gives status", 64'(rdata), 64'hBEEF);
        @(negedge clk);
    endtask

    task automatic t_enable;
        access(1'b1, 4'd6, 16'h00F1);
        check("R6", "pulse word1 in ack", 64'(a_p1), 64'(32'h00F1_0000));
        check("R6", "pulse gone after ack", 64'(a_p2), 64'd0);
        check("R6", "cfg untouched", 64'(cfg_bits), 64'(model));
        access(1'b0, 4'd6, '0);
        check("R6", "read enable-only zero", 64'(a_rd), 64'd0);
        check("R6", "read enable-only acked", 64'(a_ack1), 64'd1);
        access(1'b1, 4'd5, 16'h7E57);
        check("R7", "shared write pulses word0", 64'(a_p1), 64'(32'h0000_7E57));
        check("R7", "shared write no storage", 64'(cfg_bits), 64'(model));
    endtask

    task automatic t_discard;
        access(1'b1, 4'd4, 16'hDEAD);
        check("R8", "ro write cfg unchanged", 64'(cfg_bits), 64'(model));
        check("R8", "ro write no pulse", 64'(a_p1), 64'd0);
        check("R8", "ro write acked", 64'(a_ack1), 64'd1);
        access(1'b0, 4'd9, '0);
        check("R9", "unmapped read zero", 64'(a_rd), 64'd0);
        check("R9", "unmapped read acked", 64'(a_ack1), 64'd1);
        access(1'b1, 4'd15, 16'hFFFF);
        check("R9", "unmapped write cfg", 64'(cfg_bits), 64'(model));
        check("R9", "unmapped write pulse", 64'(a_p1), 64'd0);
        check("R9", "unmapped write acked", 64'(a_ack1), 64'd1);
    endtask

    task automatic t_idle;
        @(negedge clk);
        req_en = 1'b0; req_wr = 1'b1; req_addr = 4'd1; wdata = 16'h5555;
        @(negedge clk);
        check("R10", "no ack when idle", 64'(ack), 64'd0);
        req_addr = 4'd5;
        @(negedge clk);
        check("R10", "no pulse when idle", 64'(enable_pulse), 64'd0);
        check("R10", "cfg unchanged when idle", 64'(cfg_bits), 64'(model));
        req_wr = 1'b0; req_addr = '0; wdata = '0;
    endtask

    task automatic t_busy;
        @(negedge clk);
        req_en = 1'b1; req_wr = 1'b1; req_addr = 4'd1; wdata = 16'h0C0C;
        model[1*DW +: DW] = 16'h0C0C;
        @(negedge clk);
        check("R11", "first ack", 64'(ack), 64'd1);
        req_addr = 4'd3; wdata = 16'h9999;
        @(negedge clk);
        req_en = 1'b0; req_wr = 1'b0;
        check("R11", "no second ack", 64'(ack), 64'd0);
        check("R11", "busy write dropped", 64'(cfg_bits), 64'(model));
        @(negedge clk);
        check("R11", "cfg still intact", 64'(cfg_bits), 64'(model));
    endtask

    initial begin
        model = INIT;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rw();
        t_status();
        t_enable();
        t_discard();
        t_idle();
        t_busy();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = INIT;
        t_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule